// File: doc/BRIEF.md
# Multi-Frequency Tone-Pair Qualifier

This block follows a bank of six threshold detectors in a multi-frequency signalling receiver. Channels 0 to 5 stand for the 700, 900, 1100, 1300, 1500 and 1700 Hz tones. On every frame tick, about once per 2.3 ms, it samples the six active flags. It then sorts the frame into one of three kinds: silence (no channel active), a pair (exactly two channels active) or a bad pattern (one channel active, or three or more).

In qualify mode, a pair is reported only after the same two channels have stayed active for a set number of consecutive frames. The key-pulse pair can be given a longer wait when the long-KP control is high. Once a pair is reported it stays up through short dropouts. A bad pattern that persists is reported as an error.

In bypass mode, each frame's raw classification goes straight to the outputs with no duration check. All outputs change only on a frame tick.

Top module: `mf_pair_qualifier`

## Requirements
- R1: After reset, `pair_code`, `valid_evt` and `error_evt` are all zero.
- R2: The outputs change only on a clock edge where `frame_tick` is high. Between ticks they hold their values whatever the other inputs do.
- R3: Bypass mode (`qual_en` low at the tick): a frame with exactly two flags set drives `pair_code` to the flags, `valid_evt` to 1 and `error_evt` to 0 at that same tick.
- R4: Bypass mode: a frame with no flags gives all outputs zero. A frame with one flag, or with three or more flags, gives `error_evt`=1, `valid_evt`=0 and `pair_code`=0.
- R5: Qualify mode: a pair is declared (`valid_evt`=1, `pair_code`=flags) at the NORM_FRAMES-th consecutive frame of the same pair, and not earlier. The default is 13 frames.
- R6: Qualify mode: a frame carrying a different pair restarts the consecutive count at one.
- R7: The key-pulse pair is channels 2 and 5 (`tone_flags`=6'b100100). With `long_kp` high it needs LONG_FRAMES consecutive frames (default 24). With `long_kp` low it needs NORM_FRAMES, like every other pair.
- R8: A declared pair survives up to HOLD_FRAMES-1 consecutive non-matching frames (default 3). On the HOLD_FRAMES-th consecutive non-matching frame, `valid_evt` and `pair_code` clear to zero.
- R9: Qualify mode: a bad pattern raises `error_evt` at its NORM_FRAMES-th consecutive frame. The error is suppressed while a pair is declared, and it clears on the first frame that is not a bad pattern.
- R10: `valid_evt` and `error_evt` are never high together. `pair_code` has exactly two bits set when `valid_evt` is high and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse marking a frame boundary; flags are sampled here |
| tone_flags | input | 6 | Per-channel threshold detector flags, bit i = channel i |
| qual_en | input | 1 | 1 = duration qualification, 0 = raw bypass |
| long_kp | input | 1 | 1 = key-pulse pair needs the long detect count |
| pair_code | output | 6 | Declared pair as two set bits, zero when none |
| valid_evt | output | 1 | A pair is declared |
| error_evt | output | 1 | A bad pattern is being reported |

## Verification
Every result is registered once, at the clock edge that samples `frame_tick`. The bench therefore raises the tick at a falling edge, drops it at the next falling edge, and reads the outputs there, one cycle after the tick.

Duration results are due on an exact frame count. The bench checks the frame just before the threshold (where the output must still be low) and the threshold frame itself (where it must be high), for the normal count, the long key-pulse count, the dropout hold and the error count.

Stability between ticks is checked by changing the flags and modes for several cycles without a tick and confirming that no output moves.

// File: rtl/mfq_pkg.sv
package mfq_pkg;
  localparam int CH = 6;

  typedef enum logic [1:0] {FR_SILENT, FR_PAIR, FR_BAD} frame_kind_e;

  localparam logic [CH-1:0] KP_CHANNELS = 6'b100100;

  function automatic int unsigned active_count(input logic [CH-1:0] f);
    int unsigned n;
    n = 0;
    for (int i = 0; i < CH; i++) n += int'(f[i]);
    return n;
  endfunction

  function automatic frame_kind_e kind_of(input logic [CH-1:0] f);
    int unsigned n;
    n = active_count(f);
    if (n == 0) return FR_SILENT;
    if (n == 2) return FR_PAIR;
    return FR_BAD;
  endfunction
endpackage

// File: rtl/mfq_classify.sv
module mfq_classify
  import mfq_pkg::*;
(
  input  logic [CH-1:0] flags,
  output frame_kind_e   kind,
  output logic          is_kp
);
  always_comb begin
    kind  = kind_of(flags);
    is_kp = (flags == KP_CHANNELS);
  end
endmodule

// File: rtl/mfq_duration.sv
module mfq_duration
  import mfq_pkg::*;
#(
  parameter int NORM_FRAMES = 13,
  parameter int LONG_FRAMES = 24,
  parameter int HOLD_FRAMES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          long_kp,
  input  logic [CH-1:0] flags,
  input  frame_kind_e   kind,
  input  logic          is_kp,
  output logic [CH-1:0] det_pair,
  output logic          det_valid,
  output logic          det_error
);
  localparam int MAXF = (LONG_FRAMES > NORM_FRAMES) ? LONG_FRAMES : NORM_FRAMES;
  localparam int CW   = $clog2(MAXF + 1);
  localparam int MW   = $clog2(HOLD_FRAMES + 1);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [MW-1:0] MMAX = {MW{1'b1}};

  logic [CW-1:0] run_q, run_n, err_q, err_n, need;
  logic [MW-1:0] miss_q, miss_n;
  logic [CH-1:0] cand_q, pair_q, pair_n;
  logic          held_q, held_n, errf_q, errf_n;
  logic          same_cand, hit, match_held;

  always_comb begin
    same_cand  = (kind == FR_PAIR) && (flags == cand_q);
    if (kind != FR_PAIR)  run_n = '0;
    else if (same_cand)   run_n = (run_q == CMAX) ? run_q : run_q + 1'b1;
    else                  run_n = CW'(1);
    need       = (is_kp && long_kp) ? CW'(LONG_FRAMES) : CW'(NORM_FRAMES);
    hit        = (kind == FR_PAIR) && (run_n >= need);
    match_held = held_q && (kind == FR_PAIR) && (flags == pair_q);
    if (hit || match_held) miss_n = '0;
    else if (held_q)       miss_n = (miss_q == MMAX) ? miss_q : miss_q + 1'b1;
    else                   miss_n = '0;
    held_n = hit || (held_q && (miss_n < MW'(HOLD_FRAMES)));
    pair_n = hit ? flags : (held_n ? pair_q : '0);
    if (kind == FR_BAD) err_n = (err_q == CMAX) ? err_q : err_q + 1'b1;
    else                err_n = '0;
    errf_n = !held_n && (err_n >= CW'(NORM_FRAMES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0; err_q <= '0; miss_q <= '0; cand_q <= '0;
      pair_q <= '0; held_q <= 1'b0; errf_q <= 1'b0;
    end else if (tick) begin
      if (enable) begin
        run_q  <= run_n;
        err_q  <= err_n;
        miss_q <= miss_n;
        cand_q <= (kind == FR_PAIR) ? flags : '0;
        pair_q <= pair_n;
        held_q <= held_n;
        errf_q <= errf_n;
      end else begin
        run_q <= '0; err_q <= '0; miss_q <= '0; cand_q <= '0;
        pair_q <= '0; held_q <= 1'b0; errf_q <= 1'b0;
      end
    end
  end

  assign det_pair  = pair_q;
  assign det_valid = held_q;
  assign det_error = errf_q;

  // R5: a declaration appears only once the run counter has reached the normal count
  a_r5_rise_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> (run_q >= CW'(NORM_FRAMES)));

  // R8: a held pair never carries a miss count at or above the hold limit
  a_r8_miss_bound: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> (miss_q < MW'(HOLD_FRAMES)));

  // R9: the error flag is backed by a long enough run of bad frames
  a_r9_err_count: assert property (@(posedge clk) disable iff (!rst_n)
    errf_q |-> (err_q >= CW'(NORM_FRAMES)));
endmodule

// File: rtl/mf_pair_qualifier.sv
module mf_pair_qualifier
  import mfq_pkg::*;
#(
  parameter int NORM_FRAMES = 13,
  parameter int LONG_FRAMES = 24,
  parameter int HOLD_FRAMES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_tick,
  input  logic [5:0] tone_flags,
  input  logic       qual_en,
  input  logic       long_kp,
  output logic [5:0] pair_code,
  output logic       valid_evt,
  output logic       error_evt
);
  frame_kind_e   kind;
  logic          is_kp;
  logic [CH-1:0] q_pair;
  logic          q_valid, q_error;
  logic [CH-1:0] b_pair;
  logic          b_valid, b_error, mode_q;

  mfq_classify u_cls (
    .flags (tone_flags),
    .kind  (kind),
    .is_kp (is_kp)
  );

  mfq_duration #(
    .NORM_FRAMES (NORM_FRAMES),
    .LONG_FRAMES (LONG_FRAMES),
    .HOLD_FRAMES (HOLD_FRAMES)
  ) u_dur (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (frame_tick),
    .enable    (qual_en),
    .long_kp   (long_kp),
    .flags     (tone_flags),
    .kind      (kind),
    .is_kp     (is_kp),
    .det_pair  (q_pair),
    .det_valid (q_valid),
    .det_error (q_error)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_pair <= '0; b_valid <= 1'b0; b_error <= 1'b0; mode_q <= 1'b0;
    end else if (frame_tick) begin
      mode_q  <= qual_en;
      b_pair  <= (kind == FR_PAIR) ? tone_flags : '0;
      b_valid <= (kind == FR_PAIR);
      b_error <= (kind == FR_BAD);
    end
  end

  assign pair_code = mode_q ? q_pair  : b_pair;
  assign valid_evt = mode_q ? q_valid : b_valid;
  assign error_evt = mode_q ? q_error : b_error;

  // R2: no output moves without a frame tick
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(pair_code) && $stable(valid_evt) && $stable(error_evt)));

  // R10: valid and error are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_evt && error_evt));

  // R10: pair code shape follows valid
  a_r10_pair_shape: assert property (@(posedge clk) disable iff (!rst_n)
    valid_evt ? ($countones(pair_code) == 2) : (pair_code == '0));
endmodule

// File: tb/tb_mf_pair_qualifier.sv
`timescale 1ns/1ps
module tb_mf_pair_qualifier;
  localparam int NORM = 13;
  localparam int LONG = 24;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic [5:0] tone_flags = '0;
  logic       qual_en = 1'b1;
  logic       long_kp = 1'b0;
  logic [5:0] pair_code;
  logic       valid_evt, error_evt;
  int         n_checks = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  mf_pair_qualifier #(.NORM_FRAMES(NORM), .LONG_FRAMES(LONG), .HOLD_FRAMES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .tone_flags(tone_flags),
    .qual_en(qual_en), .long_kp(long_kp), .pair_code(pair_code),
    .valid_evt(valid_evt), .error_evt(error_evt)
  );

  task automatic expect_out(input string req, input logic [5:0] ep, input logic ev, input logic ee);
    n_checks++;
    if (pair_code !== ep || valid_evt !== ev || error_evt !== ee) begin
      n_fail++;
      $display("FAIL %s: actual pair=%b valid=%b error=%b expected pair=%b valid=%b error=%b",
               req, pair_code, valid_evt, error_evt, ep, ev, ee);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; frame_tick = 1'b0; tone_flags = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic frame(input logic [5:0] f);
    @(negedge clk); tone_flags = f; frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic frames(input logic [5:0] f, input int n);
    for (int i = 0; i < n; i++) frame(f);
  endtask

  task automatic t_reset();
    do_reset();
    expect_out("R1 reset", 6'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bypass();
    do_reset(); qual_en = 1'b0;
    frame(6'b000011); expect_out("R3 bypass pair", 6'b000011, 1'b1, 1'b0);
    frame(6'b100001); expect_out("R3 bypass pair 0-5", 6'b100001, 1'b1, 1'b0);
    frame(6'b000000); expect_out("R4 bypass silence", 6'b0, 1'b0, 1'b0);
    frame(6'b000100); expect_out("R4 bypass one tone", 6'b0, 1'b0, 1'b1);
    frame(6'b010101); expect_out("R4 bypass three tones", 6'b0, 1'b0, 1'b1);
    qual_en = 1'b1;
  endtask

  task automatic t_normal();
    do_reset();
    frames(6'b001010, NORM - 1); expect_out("R5 before count", 6'b0, 1'b0, 1'b0);
    frame(6'b001010);            expect_out("R5 at count", 6'b001010, 1'b1, 1'b0);
  endtask

  task automatic t_restart();
    do_reset();
    frames(6'b000101, 6);
    frames(6'b011000, NORM - 1); expect_out("R6 restarted before count", 6'b0, 1'b0, 1'b0);
    frame(6'b011000);            expect_out("R6 restarted at count", 6'b011000, 1'b1, 1'b0);
  endtask

  task automatic t_kp();
    do_reset(); long_kp = 1'b1;
    frames(6'b100100, LONG - 1); expect_out("R7 long kp before", 6'b0, 1'b0, 1'b0);
    frame(6'b100100);            expect_out("R7 long kp at count", 6'b100100, 1'b1, 1'b0);
    do_reset();
    frames(6'b000011, NORM);     expect_out("R7 other pair ignores long_kp", 6'b000011, 1'b1, 1'b0);
    do_reset(); long_kp = 1'b0;
    frames(6'b100100, NORM);     expect_out("R7 short kp at count", 6'b100100, 1'b1, 1'b0);
  endtask

  task automatic t_hold();
    do_reset();
    frames(6'b110000, NORM);
    frames(6'b000000, HOLD - 1); expect_out("R8 dropout tolerated", 6'b110000, 1'b1, 1'b0);
    frame(6'b110000);            expect_out("R8 pair resumes", 6'b110000, 1'b1, 1'b0);
    frames(6'b000000, HOLD - 1); expect_out("R8 still held", 6'b110000, 1'b1, 1'b0);
    frame(6'b000000);            expect_out("R8 released", 6'b0, 1'b0, 1'b0);
  endtask

  task automatic t_error();
    do_reset();
    frames(6'b000111, NORM - 1); expect_out("R9 bad before count", 6'b0, 1'b0, 1'b0);
    frame(6'b000111);            expect_out("R9 bad at count", 6'b0, 1'b0, 1'b1);
    frame(6'b000000);            expect_out("R9 error clears", 6'b0, 1'b0, 0);
    do_reset();
    frames(6'b000011, NORM);
    frames(6'b001000, NORM - 1); expect_out("R9 R10 suppressed then released", 6'b0, 1'b0, 1'b0);
    frame(6'b001000);            expect_out("R9 error after release", 6'b0, 1'b0, 1'b1);
  endtask

  task automatic t_stable();
    do_reset(); qual_en = 1'b0;
    frame(6'b010010);
    @(negedge clk); tone_flags = 6'b111111; qual_en = 1'b1; long_kp = 1'b1;
    repeat (5) @(negedge clk);
    expect_out("R2 stable between ticks", 6'b010010, 1'b1, 1'b0);
    long_kp = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_normal();
    t_restart();
    t_kp();
    t_hold();
    t_error();
    t_stable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule